// File: doc/BRIEF.md
# Skewed-Range Signed Adder

This block adds two words of a signed code in which only one quarter of the code space is negative. A word counts as negative only when its two most significant bits are both 1. Negative words keep the usual two's complement bit patterns. Every other pattern is read as a plain unsigned value. With the default width of 8 bits, the values run from -64 (code 8'hC0) up to +191 (code 8'hBF). The block is useful in a datapath that needs a few small negative numbers and headroom a little above the usual signed maximum.

The block is purely combinational. It returns the low bits of the binary sum and a sign flag for each operand and for the result. It also returns three overflow detectors, one for each sign case: both operands negative, both non-negative, and mixed signs. The detectors use only inversion, AND and OR, and none of them looks at the operand signs. A final overflow output uses the operand sign flags to pick the detector that applies. When no overflow is reported, the sum bits are the correct code for the true sum.

Top module: `skew_range_adder`

## Requirements
- R1: `a_neg_o` is 1 exactly when bits 7 and 6 of `op_a` are both 1 (code 8'hC0 or above), and `b_neg_o` follows the same rule for `op_b`.
- R2: `sum_o` equals the low 8 bits of the unsigned sum of the two operand codes. Whenever the true sum lies in -64..+191, `sum_o` is the code of that sum: value v ≥ 0 encodes as v, and v < 0 encodes as v+256.
- R3: `sum_neg_o` is 1 exactly when bits 7 and 6 of `sum_o` are both 1.
- R4: When both operands are negative, `ovf_negpair_o` is 1 exactly when the true sum is below -64.
- R5: When both operands are non-negative, `ovf_pospair_o` is 1 exactly when the true sum is above +191.
- R6: `ovf_mixed_o` is 0 for every operand pair, including the operand pairs with mixed signs.
- R7: `ovf_o` is 1 exactly when the true sum of the two decoded operands lies outside -64..+191.
- R8: The range edges behave as follows. 8'hC0+8'hFF overflows, and 8'hE0+8'hE0 gives 8'hC0 with no overflow. 8'hBF+8'h01 overflows, and 8'hBF+8'h00 gives 8'hBF with no overflow. 8'hC0+8'hBF gives 8'h7F with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH (8) | First operand code |
| op_b | input | WIDTH (8) | Second operand code |
| sum_o | output | WIDTH (8) | Low bits of the sum |
| a_neg_o | output | 1 | First operand is negative |
| b_neg_o | output | 1 | Second operand is negative |
| sum_neg_o | output | 1 | Result code is negative |
| ovf_negpair_o | output | 1 | Detector for the case where both operands are negative |
| ovf_pospair_o | output | 1 | Detector for the case where both operands are non-negative |
| ovf_mixed_o | output | 1 | Detector for the mixed-sign case |
| ovf_o | output | 1 | Overflow for the actual sign case |

## Verification
The bench builds the block with its default WIDTH of 8. At that width the operand space has only 65,536 pairs, so the bench applies every pair. An integer model decodes each operand, and every pair is checked against it. This sweep covers every sign combination. It also covers every carry pattern through the ripple chain and both edges of the skewed range, from each side. The listed edge pairs are applied again as named cases, so that a fault at a range limit is reported under its own requirement.

// File: rtl/skew_pkg.sv
package skew_pkg;

    // Default datapath width of the skewed signed code.
    localparam int DEF_WIDTH = 8;

    // One detector output for each combination of operand signs.
    typedef struct packed {
        logic neg_pair;
        logic pos_pair;
        logic mixed;
    } ovf_cases_t;

endpackage

// File: rtl/skew_sign_decode.sv
// Decodes whether a word of the skewed code is negative: its top two bits
// must both be set.
module skew_sign_decode #(
    parameter int WIDTH = skew_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             neg_o
);
    localparam int TOP  = WIDTH - 1;
    localparam int NEXT = WIDTH - 2;

    assign neg_o = word_i[TOP] & word_i[NEXT];
endmodule

// File: rtl/skew_ripple_adder.sv
// Plain ripple-carry adder made from one full-adder slice per bit.
module skew_ripple_adder #(
    parameter int WIDTH = skew_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] s_o,
    output logic             cout_o
);
    logic [WIDTH:0] carry;

    assign carry[0] = 1'b0;

    for (genvar k = 0; k < WIDTH; k++) begin : g_slice
        logic prop;
        logic gen;
        assign prop       = x_i[k] ^ y_i[k];
        assign gen        = x_i[k] & y_i[k];
        assign s_o[k]     = prop ^ carry[k];
        assign carry[k+1] = gen | (prop & carry[k]);
    end

    assign cout_o = carry[WIDTH];
endmodule

// File: rtl/skew_ovf_detect.sv
// Overflow detectors for the three sign cases, built from NOT, AND and OR.
// None of them checks the operand signs. The final flag is chosen using the
// sign flags.
module skew_ovf_detect #(
    parameter int WIDTH = skew_pkg::DEF_WIDTH
) (
    input  logic                  s_top_i,
    input  logic                  s_next_i,
    input  logic                  cout_i,
    input  logic                  a_neg_i,
    input  logic                  b_neg_i,
    output skew_pkg::ovf_cases_t  cases_o,
    output logic                  ovf_o
);
    logic sum_in_neg_band;

    assign sum_in_neg_band = s_top_i & s_next_i;

    // Two negatives: the raw sum always has its top bit set, and it stays
    // in range only if it also lands in the negative band.
    assign cases_o.neg_pair = ~sum_in_neg_band;

    // Two non-negatives: a carry out, or a result that lands in the negative
    // band, means the true sum went past the positive limit.
    assign cases_o.pos_pair = cout_i | sum_in_neg_band;

    // One of each sign: the true sum always falls inside the range.
    assign cases_o.mixed = 1'b0;

    assign ovf_o = (a_neg_i & b_neg_i & cases_o.neg_pair)
                 | (~a_neg_i & ~b_neg_i & cases_o.pos_pair)
                 | ((a_neg_i ^ b_neg_i) & cases_o.mixed);

    if (WIDTH < 3) begin : g_width_guard
        initial $fatal(1, "skew_ovf_detect: WIDTH must be at least 3");
    end
endmodule

// File: rtl/skew_range_adder.sv
// Top level of the adder for the skewed signed code.
module skew_range_adder #(
    parameter int WIDTH = skew_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum_o,
    output logic             a_neg_o,
    output logic             b_neg_o,
    output logic             sum_neg_o,
    output logic             ovf_negpair_o,
    output logic             ovf_pospair_o,
    output logic             ovf_mixed_o,
    output logic             ovf_o
);
    localparam int NWORDS = 3;

    logic [WIDTH-1:0]     raw_sum;
    logic                 carry_out;
    logic [WIDTH-1:0]     words [NWORDS];
    logic [NWORDS-1:0]    negs;
    skew_pkg::ovf_cases_t cases;

    skew_ripple_adder #(.WIDTH(WIDTH)) adder_i (
        .x_i    (op_a),
        .y_i    (op_b),
        .s_o    (raw_sum),
        .cout_o (carry_out)
    );

    assign words[0] = op_a;
    assign words[1] = op_b;
    assign words[2] = raw_sum;

    for (genvar w = 0; w < NWORDS; w++) begin : g_sign
        skew_sign_decode #(.WIDTH(WIDTH)) dec_i (
            .word_i (words[w]),
            .neg_o  (negs[w])
        );
    end

    skew_ovf_detect #(.WIDTH(WIDTH)) ovf_i (
        .s_top_i  (raw_sum[WIDTH-1]),
        .s_next_i (raw_sum[WIDTH-2]),
        .cout_i   (carry_out),
        .a_neg_i  (negs[0]),
        .b_neg_i  (negs[1]),
        .cases_o  (cases),
        .ovf_o    (ovf_o)
    );

    assign sum_o         = raw_sum;
    assign a_neg_o       = negs[0];
    assign b_neg_o       = negs[1];
    assign sum_neg_o     = negs[2];
    assign ovf_negpair_o = cases.neg_pair;
    assign ovf_pospair_o = cases.pos_pair;
    assign ovf_mixed_o   = cases.mixed;
endmodule

// File: rtl/skew_range_adder_chk.sv
// Checker for the skewed-range adder, attached to the top through bind.
module skew_range_adder_chk #(
    parameter int WIDTH = skew_pkg::DEF_WIDTH
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] sum_o,
    input logic             a_neg_o,
    input logic             b_neg_o,
    input logic             sum_neg_o,
    input logic             ovf_negpair_o,
    input logic             ovf_pospair_o,
    input logic             ovf_o
);
    localparam int SPAN     = 1 << WIDTH;
    localparam int NEG_LIM  = SPAN / 4;
    localparam int NEG_CODE = SPAN - NEG_LIM;
    localparam int POS_MAX  = NEG_CODE - 1;

    function automatic int to_value(input logic [WIDTH-1:0] code);
        int u;
        u = int'(code);
        return (u >= NEG_CODE) ? (u - SPAN) : u;
    endfunction

    int             va;
    int             vb;
    int             total;
    logic [WIDTH:0] wide;

    always_comb begin
        va    = to_value(op_a);
        vb    = to_value(op_b);
        total = va + vb;
        wide  = {1'b0, op_a} + {1'b0, op_b};

        assert_sign_a_R1: assert (a_neg_o == (int'(op_a) >= NEG_CODE));
        assert_sign_b_R1: assert (b_neg_o == (int'(op_b) >= NEG_CODE));
        assert_sum_bits_R2: assert (sum_o == wide[WIDTH-1:0]);
        assert_sum_sign_R3: assert (sum_neg_o == (int'(sum_o) >= NEG_CODE));
        if (a_neg_o && b_neg_o) begin
            assert_neg_pair_R4: assert (ovf_negpair_o == (total < -NEG_LIM));
        end
        if (!a_neg_o && !b_neg_o) begin
            assert_pos_pair_R5: assert (ovf_pospair_o == (total > POS_MAX));
        end
        assert_no_overflow_R7: assert (ovf_o == ((total < -NEG_LIM) || (total > POS_MAX)));
    end
endmodule

bind skew_range_adder skew_range_adder_chk #(.WIDTH(WIDTH)) chk_i (
    .op_a          (op_a),
    .op_b          (op_b),
    .sum_o         (sum_o),
    .a_neg_o       (a_neg_o),
    .b_neg_o       (b_neg_o),
    .sum_neg_o     (sum_neg_o),
    .ovf_negpair_o (ovf_negpair_o),
    .ovf_pospair_o (ovf_pospair_o),
    .ovf_o         (ovf_o)
);

// File: tb/skew_range_adder_tb_top.sv
module skew_range_adder_tb_top;
    localparam int WIDTH    = 8;
    localparam int SPAN     = 1 << WIDTH;
    localparam int NEG_LIM  = SPAN / 4;
    localparam int NEG_CODE = SPAN - NEG_LIM;
    localparam int POS_MAX  = NEG_CODE - 1;
    localparam int WD_LIMIT = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] op_a = '0;
    logic [WIDTH-1:0] op_b = '0;
    logic [WIDTH-1:0] sum_o;
    logic             a_neg_o, b_neg_o, sum_neg_o;
    logic             ovf_negpair_o, ovf_pospair_o, ovf_mixed_o, ovf_o;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    skew_range_adder #(.WIDTH(WIDTH)) dut_i (
        .op_a          (op_a),
        .op_b          (op_b),
        .sum_o         (sum_o),
        .a_neg_o       (a_neg_o),
        .b_neg_o       (b_neg_o),
        .sum_neg_o     (sum_neg_o),
        .ovf_negpair_o (ovf_negpair_o),
        .ovf_pospair_o (ovf_pospair_o),
        .ovf_mixed_o   (ovf_mixed_o),
        .ovf_o         (ovf_o)
    );

    function automatic int decode(input int code);
        return (code >= NEG_CODE) ? (code - SPAN) : code;
    endfunction

    task automatic check(input string req, input int actual, input int expected,
                         input int a, input int b);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s a=%02h b=%02h actual=%0d expected=%0d", req, a, b, actual, expected);
        end
    endtask

    // Drive one pair just after a rising edge, then check it at the next falling edge.
    task automatic apply_and_check(input int a, input int b);
        int va, vb, tot, exp_sum;
        @(posedge clk);
        #1;
        op_a = a[WIDTH-1:0];
        op_b = b[WIDTH-1:0];
        @(negedge clk);
        va      = decode(a);
        vb      = decode(b);
        tot     = va + vb;
        exp_sum = tot & (SPAN - 1);
        check("R1 a_neg", int'(a_neg_o), int'(a >= NEG_CODE), a, b);
        check("R1 b_neg", int'(b_neg_o), int'(b >= NEG_CODE), a, b);
        check("R2 sum", int'(sum_o), exp_sum, a, b);
        check("R3 sum_neg", int'(sum_neg_o), int'(exp_sum >= NEG_CODE), a, b);
        if (va < 0 && vb < 0)
            check("R4 negpair", int'(ovf_negpair_o), int'(tot < -NEG_LIM), a, b);
        if (va >= 0 && vb >= 0)
            check("R5 pospair", int'(ovf_pospair_o), int'(tot > POS_MAX), a, b);
        check("R6 mixed", int'(ovf_mixed_o), 0, a, b);
        check("R7 ovf", int'(ovf_o), int'(tot < -NEG_LIM || tot > POS_MAX), a, b);
    endtask

    task automatic edge_case(input int a, input int b, input int exp_sum, input int exp_ovf);
        apply_and_check(a, b);
        check("R8 edge ovf", int'(ovf_o), exp_ovf, a, b);
        if (exp_ovf == 0) check("R8 edge sum", int'(sum_o), exp_sum, a, b);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT && !done) begin
                n_errors++;
                n_checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WD_LIMIT);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Zero operands: all outputs idle (R2, R3, R7).
        @(negedge clk);
        check("R2 zero sum", int'(sum_o), 0, 0, 0);
        check("R3 zero sign", int'(sum_neg_o), 0, 0, 0);
        check("R7 zero ovf", int'(ovf_o), 0, 0, 0);

        // R8 named range edges.
        edge_case(8'hC0, 8'hFF, 0, 1);
        edge_case(8'hE0, 8'hE0, 8'hC0, 0);
        edge_case(8'hBF, 8'h01, 0, 1);
        edge_case(8'hBF, 8'h00, 8'hBF, 0);
        edge_case(8'hC0, 8'hBF, 8'h7F, 0);

        // Exhaustive sweep over every operand pair (R1..R7).
        for (int i = 0; i < SPAN * SPAN; i++) begin
            apply_and_check(i / SPAN, i % SPAN);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule